// File: doc/BRIEF.md
# Windowed Register File

This block is an integer register file that presents 32 architectural registers per window while storing them in a larger physical array. Registers r0 to r7 are globals shared by every window. The other 24 form three groups of eight: incoming arguments (r24 to r31), window-private locals (r16 to r23) and outgoing arguments (r8 to r15). A current window pointer picks the active window. Neighbouring windows overlap, so the outgoing group of window w-1 and the incoming group of window w are the same physical storage. Values can pass between windows without being copied.

Two combinational read ports and one clocked write port take 5-bit architectural register numbers. A window command input moves the pointer. A step-down command lowers it by one and a step-up command raises it by one, both modulo the window count. A mask register holds one invalid bit per window. When a command targets a window whose bit is set, the pointer stays where it is and a one-cycle trap flag reports the event.

Window control is a small state machine with three states. ST_CLEAN means the last command raised no trap. ST_OVFL means the last step-down hit an invalid window. ST_UNFL means the last step-up hit an invalid window. The transitions are evaluated every cycle from any state. The transition go_ovfl fires on a step-down into a masked window. The transition go_unfl fires on a step-up into a masked window. The transition go_clean fires on every other cycle, including a successful move and an idle or reserved command.

Top module: `win_regfile`

## Requirements
- R1: Registers r1 to r7 are global: a value written to one of them in any window reads back unchanged in every other window.
- R2: Register r0 reads as zero on both read ports. A write to r0 changes nothing that either read port can observe.
- R3: Outgoing registers r8+k of window w-1 and incoming registers r24+k of window w (window numbers modulo NWIN, k in 0..7) are the same storage. A value written through one name reads back through the other.
- R4: Locals r16 to r23 are private to each window. A write to a local in one window does not change the locals of any other window.
- R5: Command code 2'b01 (step-down) sets the pointer to (cwp-1) mod NWIN. Code 2'b10 (step-up) sets it to (cwp+1) mod NWIN. Each takes effect at the clock edge, provided the target window's mask bit is clear.
- R6: A step-down whose target window has its mask bit set leaves the pointer unchanged and drives `ovfl_o` high for exactly the one cycle after that edge.
- R7: A step-up whose target window has its mask bit set leaves the pointer unchanged and drives `unfl_o` high for exactly the one cycle after that edge.
- R8: Reads are combinational. A write lands at the clock edge, and a read of that register in the same cycle still returns the previous value.
- R9: After reset the pointer is 0, the mask is all clear, and both trap flags are low.
- R10: Command codes 2'b00 and 2'b11 leave the pointer unchanged and raise no flag. A mask load (`wim_we`) takes effect at the edge, so a command issued in the same cycle is checked against the old mask.
- R11: A register write issued in the same cycle as a pointer move is mapped through the window that was current before the move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A architectural register number |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | 5 | Read port B architectural register number |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write architectural register number |
| wr_data | input | XLEN | Write data |
| win_cmd | input | 2 | Window command: 00 idle, 01 step-down, 10 step-up, 11 idle |
| wim_we | input | 1 | Load the invalid-window mask |
| wim_val | input | NWIN | New mask value, bit w flags window w invalid |
| cwp_o | output | CW | Current window pointer |
| ovfl_o | output | 1 | Step-down trap flag |
| unfl_o | output | 1 | Step-up trap flag |

## Verification
The bench builds the block with NWIN = 5, a window count that is not a power of two. The pointer then wraps from 0 down to 4 and from 4 up to 0, which reaches the modulo logic that a power-of-two count would hide behind plain truncation. With five windows, one round trip through the wrap also lets a single test show both the overlap between windows 4 and 0 and the privacy of their locals. The same short run then sets mask bits on both neighbours of window 0 to reach both trap paths.

// File: rtl/win_rf_pkg.sv
package win_rf_pkg;

    localparam int unsigned GRP_SIZE = 8;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'b00,
        CMD_SAVE    = 2'b01,
        CMD_RESTORE = 2'b10,
        CMD_RSVD    = 2'b11
    } win_cmd_e;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_OVFL  = 2'b01,
        ST_UNFL  = 2'b10
    } win_st_e;

endpackage

// File: rtl/win_addr_map.sv
module win_addr_map #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned CW   = 3,
    parameter int unsigned PW   = 8
) (
    input  logic [4:0]    arch_idx,
    input  logic [CW-1:0] cwp,
    output logic [PW-1:0] phys_idx
);
    import win_rf_pkg::*;

    localparam int unsigned SHARED_BASE = GRP_SIZE;
    localparam int unsigned LOCAL_BASE  = GRP_SIZE + NWIN * GRP_SIZE;

    int lin;
    int grp;
    int off;

    always_comb begin
        off = int'(arch_idx[2:0]);
        grp = 0;
        unique case (arch_idx[4:3])
            2'd0: lin = off;
            2'd1: begin
                // outgoing group of window w is incoming group of window w+1
                grp = (int'(cwp) == int'(NWIN) - 1) ? 0 : int'(cwp) + 1;
                lin = int'(SHARED_BASE) + grp * int'(GRP_SIZE) + off;
            end
            2'd2: lin = int'(LOCAL_BASE) + int'(cwp) * int'(GRP_SIZE) + off;
            default: lin = int'(SHARED_BASE) + int'(cwp) * int'(GRP_SIZE) + off;
        endcase
        phys_idx = PW'(lin);
    end

endmodule

// File: rtl/win_storage.sv
module win_storage #(
    parameter int unsigned NPHYS = 136,
    parameter int unsigned XLEN  = 32,
    parameter int unsigned PW    = 8
) (
    input  logic            clk,
    input  logic            we,
    input  logic [PW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [PW-1:0]   raddr_a,
    input  logic [PW-1:0]   raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b
);
    logic [XLEN-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/win_ctrl.sv
module win_ctrl #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned CW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cmd,
    input  logic            wim_we,
    input  logic [NWIN-1:0] wim_val,
    output logic [CW-1:0]   cwp_o,
    output logic            ovfl_o,
    output logic            unfl_o
);
    import win_rf_pkg::*;

    win_st_e         state_q, state_d;
    logic [CW-1:0]   cwp_q, cwp_d;
    logic [NWIN-1:0] wim_q;
    logic [CW-1:0]   dec_w, inc_w;
    win_cmd_e        cmd_e;

    assign cmd_e = win_cmd_e'(cmd);

    always_comb begin
        dec_w = (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - 1'b1;
        inc_w = (int'(cwp_q) == int'(NWIN) - 1) ? '0 : cwp_q + 1'b1;
    end

    // next-state and pointer decision
    always_comb begin
        state_d = ST_CLEAN;
        cwp_d   = cwp_q;
        unique case (cmd_e)
            CMD_SAVE: begin
                if (wim_q[dec_w]) state_d = ST_OVFL;
                else              cwp_d   = dec_w;
            end
            CMD_RESTORE: begin
                if (wim_q[inc_w]) state_d = ST_UNFL;
                else              cwp_d   = inc_w;
            end
            default: state_d = ST_CLEAN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
            cwp_q   <= '0;
            wim_q   <= '0;
        end else begin
            state_q <= state_d;
            cwp_q   <= cwp_d;
            if (wim_we) wim_q <= wim_val;
        end
    end

    // outputs
    always_comb begin
        ovfl_o = 1'b0;
        unfl_o = 1'b0;
        unique case (state_q)
            ST_OVFL:  ovfl_o = 1'b1;
            ST_UNFL:  unfl_o = 1'b1;
            default:  ;
        endcase
    end

    assign cwp_o = cwp_q;

    // R5
    save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_e == CMD_SAVE && !wim_q[dec_w]) |=>
            (int'(cwp_q) == (int'($past(cwp_q)) + int'(NWIN) - 1) % int'(NWIN)));

    // R6
    ovfl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_e == CMD_SAVE && wim_q[dec_w]) |=> ($stable(cwp_q) && ovfl_o));

    // R7
    unfl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_e == CMD_RESTORE && wim_q[inc_w]) |=> ($stable(cwp_q) && unfl_o));

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovfl_o, unfl_o}));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_e == CMD_IDLE || cmd_e == CMD_RSVD) |=> ($stable(cwp_q) && !ovfl_o && !unfl_o));

    // R9
    cwp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cwp_q) < int'(NWIN));

endmodule

// File: rtl/win_regfile.sv
module win_regfile #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned XLEN = 32,
    localparam int unsigned CW    = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int unsigned NPHYS = 8 + 16 * NWIN,
    localparam int unsigned PW    = $clog2(NPHYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [4:0]      rd_b_idx,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic [1:0]      win_cmd,
    input  logic            wim_we,
    input  logic [NWIN-1:0] wim_val,
    output logic [CW-1:0]   cwp_o,
    output logic            ovfl_o,
    output logic            unfl_o
);
    logic [CW-1:0]   cwp;
    logic [PW-1:0]   pa_a, pa_b, pa_w;
    logic [XLEN-1:0] raw_a, raw_b;
    logic            mem_we;

    win_ctrl #(.NWIN(NWIN), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd(win_cmd),
        .wim_we(wim_we), .wim_val(wim_val),
        .cwp_o(cwp), .ovfl_o(ovfl_o), .unfl_o(unfl_o)
    );

    win_addr_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map_a (
        .arch_idx(rd_a_idx), .cwp(cwp), .phys_idx(pa_a));
    win_addr_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map_b (
        .arch_idx(rd_b_idx), .cwp(cwp), .phys_idx(pa_b));
    win_addr_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map_w (
        .arch_idx(wr_idx), .cwp(cwp), .phys_idx(pa_w));

    assign mem_we = wr_en && (wr_idx != 5'd0);

    win_storage #(.NPHYS(NPHYS), .XLEN(XLEN), .PW(PW)) u_store (
        .clk(clk), .we(mem_we), .waddr(pa_w), .wdata(wr_data),
        .raddr_a(pa_a), .raddr_b(pa_b), .rdata_a(raw_a), .rdata_b(raw_b)
    );

    assign rd_a_data = (rd_a_idx == 5'd0) ? '0 : raw_a;
    assign rd_b_data = (rd_b_idx == 5'd0) ? '0 : raw_b;
    assign cwp_o     = cwp;

    // R2
    r0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 5'd0) |-> !mem_we);

endmodule

// File: tb/win_regfile_tb.sv
module win_regfile_tb;
    localparam int NW = 5;
    localparam int XL = 32;
    localparam int CWB = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [XL-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0, wim_we = 1'b0;
    logic [1:0]    win_cmd = 2'b00;
    logic [NW-1:0] wim_val = '0;
    logic [CWB-1:0] cwp_o;
    logic          ovfl_o, unfl_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          req;
        int          sel;
        logic [31:0] exp;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    win_regfile #(.NWIN(NW), .XLEN(XL)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .win_cmd(win_cmd), .wim_we(wim_we), .wim_val(wim_val),
        .cwp_o(cwp_o), .ovfl_o(ovfl_o), .unfl_o(unfl_o)
    );

    // sel: 0 rd_a, 1 rd_b, 2 pointer, 3 ovfl, 4 unfl
    task automatic expect_item(input int sel, input logic [31:0] v, input int req);
        item_t it;
        it.req = req; it.sel = sel; it.exp = v;
        sb_q.push_back(it);
    endtask

    task automatic cyc(input logic [1:0] c, input logic we, input logic [4:0] wi,
                       input logic [31:0] wd, input logic [4:0] ra, input logic [4:0] rb,
                       input logic mwe, input logic [NW-1:0] mv);
        @(negedge clk);
        win_cmd = c; wr_en = we; wr_idx = wi; wr_data = wd;
        rd_a_idx = ra; rd_b_idx = rb; wim_we = mwe; wim_val = mv;
    endtask

    // monitor: compares queued expectations shortly after each falling edge
    always @(negedge clk) begin
        item_t it;
        logic [31:0] act;
        #2;
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.sel)
                0: act = rd_a_data;
                1: act = rd_b_data;
                2: act = 32'(cwp_o);
                3: act = {31'd0, ovfl_o};
                default: act = {31'd0, unfl_o};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL R%0d sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state, R2 r0 reads zero
        cyc(2'b00, 0, 0, 0, 0, 0, 0, '0);
        expect_item(2, 0, 9); expect_item(3, 0, 9); expect_item(4, 0, 9);
        expect_item(0, 0, 2);
        cyc(2'b00, 1, 1, 32'hA1A1_0001, 0, 0, 0, '0);
        // R2 write to r0 ignored; R8 new r1 value visible after the edge
        cyc(2'b00, 1, 0, 32'hDEAD_BEEF, 1, 0, 0, '0);
        expect_item(0, 32'hA1A1_0001, 8); expect_item(1, 0, 2);
        // R8 same-cycle read returns old value
        cyc(2'b00, 1, 1, 32'hB1B1_0001, 1, 0, 0, '0);
        expect_item(0, 32'hA1A1_0001, 8); expect_item(1, 0, 2);
        cyc(2'b00, 1, 16, 32'h1000_0000, 1, 0, 0, '0);
        expect_item(0, 32'hB1B1_0001, 8);
        cyc(2'b00, 1, 8, 32'h0E00_0000, 0, 0, 0, '0);
        // R11 write during step-down lands in window 0
        cyc(2'b01, 1, 16, 32'h5050_0000, 0, 0, 0, '0);
        // R5 wrap 0 -> 4; R1 global visible
        cyc(2'b00, 1, 16, 32'h1044_0000, 1, 0, 0, '0);
        expect_item(2, 4, 5); expect_item(0, 32'hB1B1_0001, 1); expect_item(3, 0, 6);
        cyc(2'b00, 1, 8, 32'hF4F4_0000, 16, 0, 0, '0);
        expect_item(0, 32'h1044_0000, 4);
        cyc(2'b10, 0, 0, 0, 8, 0, 0, '0);
        expect_item(0, 32'hF4F4_0000, 3);
        // R5 wrap 4 -> 0; R3 overlap; R11 and R4 locals of window 0
        cyc(2'b00, 0, 0, 0, 24, 16, 0, '0);
        expect_item(2, 0, 5); expect_item(0, 32'hF4F4_0000, 3); expect_item(1, 32'h5050_0000, 11);
        cyc(2'b00, 0, 0, 0, 8, 1, 0, '0);
        expect_item(0, 32'h0E00_0000, 3); expect_item(1, 32'hB1B1_0001, 1);
        // R10 mask load and step-down same cycle: old mask used
        cyc(2'b01, 0, 0, 0, 0, 0, 1, 5'b10000);
        cyc(2'b10, 0, 0, 0, 0, 0, 0, '0);
        expect_item(2, 4, 10); expect_item(3, 0, 10);
        cyc(2'b00, 0, 0, 0, 0, 0, 0, '0);
        expect_item(2, 0, 5);
        // R6 step-down into masked window 4
        cyc(2'b01, 0, 0, 0, 0, 0, 0, '0);
        cyc(2'b00, 0, 0, 0, 0, 0, 0, '0);
        expect_item(3, 1, 6); expect_item(2, 0, 6); expect_item(4, 0, 6);
        cyc(2'b00, 0, 0, 0, 0, 0, 1, 5'b00010);
        expect_item(3, 0, 6); expect_item(2, 0, 6);
        // R7 step-up into masked window 1
        cyc(2'b10, 0, 0, 0, 0, 0, 0, '0);
        cyc(2'b00, 0, 0, 0, 0, 0, 0, '0);
        expect_item(4, 1, 7); expect_item(3, 0, 7); expect_item(2, 0, 7);
        // R10 reserved code
        cyc(2'b11, 0, 0, 0, 0, 0, 0, '0);
        expect_item(4, 0, 7);
        cyc(2'b00, 0, 0, 0, 0, 0, 1, 5'b00000);
        expect_item(2, 0, 10); expect_item(3, 0, 10); expect_item(4, 0, 10);
        // R5 step-up 0 -> 1; R3 window 1 incoming equals window 0 outgoing
        cyc(2'b10, 0, 0, 0, 0, 0, 0, '0);
        cyc(2'b00, 0, 0, 0, 24, 16, 0, '0);
        expect_item(2, 1, 5); expect_item(0, 32'h0E00_0000, 3);
        cyc(2'b00, 0, 0, 0, 0, 0, 0, '0);
        @(negedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule